// File: doc/BRIEF.md
# Indexed Colour Palette with Auto-Incrementing Host Port

This block holds a 256-entry colour palette that turns 8-bit pixel indices into red, green and blue components for a display pipeline. Each entry stores three 6-bit components. A host loads the palette through a narrow byte port. It selects a starting entry once, then streams component bytes to a single data address. The block tracks which component comes next and moves to the following entry on its own after every complete triple.

The pixel side accepts one index per clock. That index is ANDed with a host-programmable pixel mask, and the block returns the three components, each widened to 8 bits, one clock later. A separate read pointer lets the host read entries back in the same red/green/blue rhythm. A red or green byte is held in a staging register until its blue byte arrives, so an entry changes in a single step and the pixel side never sees a half-updated colour.

Top module: `pal_lut`

## Requirements
- R1: Host address decode on `hst_addr`: 0 = write pointer, 1 = colour data, 2 = read pointer, 3 = pixel mask. A host write to 0, 2 or 3 loads that register from `hst_wdata`.
- R2: Data writes are taken in the order red, green, blue. Only bits [5:0] of each byte are stored, and bits [7:6] are ignored.
- R3: An entry changes only when its blue byte is written. At that moment all three components are committed to the entry at the write pointer, and the write pointer advances by one.
- R4: Both pointers wrap from 255 to 0 when they auto-increment.
- R5: A write to the write-pointer address discards any staged red or green byte and makes the next data write a red byte.
- R6: The pixel outputs at edge k+1 show the entry at (`pix_idx` AND mask) as sampled at edge k. A mask or palette change at the same edge first takes effect for the next lookup.
- R7: Each 6-bit component c is output as the 8-bit value {c, c[5:4]}.
- R8: A host read of address 1 returns {2'b00, component} of the entry at the read pointer, in the order red, green, blue, and advances the read pointer after blue. A write to the read-pointer address restarts the sequence at red.
- R9: A host read of address 0, 2 or 3 returns the current value of that register and changes no state. `hst_rdata` is registered, is valid on the cycle after the read, and holds its value when no read is issued.
- R10: After reset both pointers are 0, both sequences start at red, the mask is 0xFF, and `hst_rdata` and the pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_wr_en | input | 1 | Host write strobe |
| hst_rd_en | input | 1 | Host read strobe |
| hst_addr | input | 2 | Host register select |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, registered |
| pix_idx | input | 8 | Pixel palette index |
| pix_r | output | 8 | Red component of the looked-up pixel |
| pix_g | output | 8 | Green component of the looked-up pixel |
| pix_b | output | 8 | Blue component of the looked-up pixel |

## Verification
If the hidden component counter slips, a colour appears at the pixel outputs rotated between channels one cycle after the affected entry is looked up. It also shows in the very next data readback. A wrong pointer puts a colour at the wrong index, and a sweep of pixel indices over the palette exposes this within one pass. A fault in the mask or the pixel register shows as a wrong colour one clock after the index is presented. The bench compares every output on every cycle against a behavioural palette model, so a divergence is reported on the first cycle it reaches a port.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int PAL_IDX_W  = 8;
    localparam int PAL_COMP_W = 6;
    localparam int PAL_OUT_W  = 8;
    localparam int PAL_HOST_W = 8;

    // host register select
    localparam logic [1:0] A_WPTR = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_RPTR = 2'd2;
    localparam logic [1:0] A_MASK = 2'd3;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int IDX_W  = pal_pkg::PAL_IDX_W,
    parameter int COMP_W = pal_pkg::PAL_COMP_W,
    localparam int DEPTH = 1 << IDX_W,
    localparam int ENT_W = 3 * COMP_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wentry,
    input  logic [IDX_W-1:0] pix_addr,
    output logic [ENT_W-1:0] pix_entry,
    input  logic [IDX_W-1:0] host_addr,
    output logic [ENT_W-1:0] host_entry
);
    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    assign pix_entry  = mem[pix_addr];
    assign host_entry = mem[host_addr];
endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
    import pal_pkg::*;
#(
    parameter int IDX_W  = PAL_IDX_W,
    parameter int COMP_W = PAL_COMP_W,
    parameter int HOST_W = PAL_HOST_W,
    localparam int ENT_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [HOST_W-1:0] wdata,
    output logic [HOST_W-1:0] rdata,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_waddr,
    output logic [ENT_W-1:0]  ram_wentry,
    input  logic [ENT_W-1:0]  ram_rentry,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  mask,
    output comp_e             wr_comp,
    output comp_e             rd_comp
);
    typedef struct packed {
        logic [IDX_W-1:0]  wr_idx;
        logic [IDX_W-1:0]  rd_idx;
        logic [IDX_W-1:0]  mask;
        comp_e             wr_comp;
        comp_e             rd_comp;
        logic [COMP_W-1:0] stage_r;
        logic [COMP_W-1:0] stage_g;
        logic [HOST_W-1:0] rdata;
    } host_st_t;

    host_st_t st_d, st_q;
    logic [COMP_W-1:0] rd_sel;

    always_comb begin
        st_d       = st_q;
        ram_we     = 1'b0;
        ram_wentry = {st_q.stage_r, st_q.stage_g, wdata[COMP_W-1:0]};

        unique case (st_q.rd_comp)
            COMP_R:  rd_sel = ram_rentry[3*COMP_W-1 -: COMP_W];
            COMP_G:  rd_sel = ram_rentry[2*COMP_W-1 -: COMP_W];
            default: rd_sel = ram_rentry[COMP_W-1:0];
        endcase

        if (rd_en) begin
            unique case (addr)
                A_WPTR: st_d.rdata = HOST_W'(st_q.wr_idx);
                A_RPTR: st_d.rdata = HOST_W'(st_q.rd_idx);
                A_MASK: st_d.rdata = HOST_W'(st_q.mask);
                default: begin
                    st_d.rdata = HOST_W'(rd_sel);
                    unique case (st_q.rd_comp)
                        COMP_R: st_d.rd_comp = COMP_G;
                        COMP_G: st_d.rd_comp = COMP_B;
                        default: begin
                            st_d.rd_comp = COMP_R;
                            st_d.rd_idx  = st_q.rd_idx + IDX_W'(1);
                        end
                    endcase
                end
            endcase
        end

        if (wr_en) begin
            unique case (addr)
                A_WPTR: begin
                    st_d.wr_idx  = wdata[IDX_W-1:0];
                    st_d.wr_comp = COMP_R;
                end
                A_RPTR: begin
                    st_d.rd_idx  = wdata[IDX_W-1:0];
                    st_d.rd_comp = COMP_R;
                end
                A_MASK: st_d.mask = wdata[IDX_W-1:0];
                default: begin
                    unique case (st_q.wr_comp)
                        COMP_R: begin
                            st_d.stage_r = wdata[COMP_W-1:0];
                            st_d.wr_comp = COMP_G;
                        end
                        COMP_G: begin
                            st_d.stage_g = wdata[COMP_W-1:0];
                            st_d.wr_comp = COMP_B;
                        end
                        default: begin
                            ram_we       = 1'b1;
                            st_d.wr_comp = COMP_R;
                            st_d.wr_idx  = st_q.wr_idx + IDX_W'(1);
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr_idx: '0, rd_idx: '0, mask: '1, wr_comp: COMP_R,
                      rd_comp: COMP_R, stage_r: '0, stage_g: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_waddr = st_q.wr_idx;
    assign wr_idx    = st_q.wr_idx;
    assign rd_idx    = st_q.rd_idx;
    assign mask      = st_q.mask;
    assign wr_comp   = st_q.wr_comp;
    assign rd_comp   = st_q.rd_comp;
    assign rdata     = st_q.rdata;
endmodule

// File: rtl/pal_pixel_path.sv
module pal_pixel_path #(
    parameter int IDX_W  = pal_pkg::PAL_IDX_W,
    parameter int COMP_W = pal_pkg::PAL_COMP_W,
    parameter int OUT_W  = pal_pkg::PAL_OUT_W,
    localparam int ENT_W = 3 * COMP_W,
    localparam int PAD_W = OUT_W - COMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] ram_addr,
    input  logic [ENT_W-1:0] ram_entry,
    output logic [OUT_W-1:0] pix_r,
    output logic [OUT_W-1:0] pix_g,
    output logic [OUT_W-1:0] pix_b
);
    typedef struct packed {
        logic [OUT_W-1:0] r;
        logic [OUT_W-1:0] g;
        logic [OUT_W-1:0] b;
    } pix_t;

    pix_t pix_d, pix_q;
    logic [OUT_W-1:0] wide [3];

    assign ram_addr = pix_idx & mask;

    for (genvar k = 0; k < 3; k++) begin : g_widen
        logic [COMP_W-1:0] c;
        assign c       = ram_entry[(3-k)*COMP_W-1 -: COMP_W];
        assign wide[k] = {c, c[COMP_W-1 -: PAD_W]};
    end

    always_comb begin
        pix_d   = pix_q;
        pix_d.r = wide[0];
        pix_d.g = wide[1];
        pix_d.b = wide[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign pix_r = pix_q.r;
    assign pix_g = pix_q.g;
    assign pix_b = pix_q.b;
endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_pkg::*;
#(
    parameter int IDX_W  = PAL_IDX_W,
    parameter int COMP_W = PAL_COMP_W,
    parameter int OUT_W  = PAL_OUT_W,
    parameter int HOST_W = PAL_HOST_W,
    localparam int ENT_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wr_en,
    input  logic              hst_rd_en,
    input  logic [1:0]        hst_addr,
    input  logic [HOST_W-1:0] hst_wdata,
    output logic [HOST_W-1:0] hst_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [OUT_W-1:0]  pix_r,
    output logic [OUT_W-1:0]  pix_g,
    output logic [OUT_W-1:0]  pix_b
);
    logic             ram_we;
    logic [IDX_W-1:0] ram_waddr;
    logic [ENT_W-1:0] ram_wentry;
    logic [ENT_W-1:0] host_entry;
    logic [IDX_W-1:0] pix_addr;
    logic [ENT_W-1:0] pix_entry;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] mask;
    comp_e            wr_comp;
    comp_e            rd_comp;

    pal_host_port #(.IDX_W(IDX_W), .COMP_W(COMP_W), .HOST_W(HOST_W)) host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (hst_wr_en),
        .rd_en      (hst_rd_en),
        .addr       (hst_addr),
        .wdata      (hst_wdata),
        .rdata      (hst_rdata),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wentry (ram_wentry),
        .ram_rentry (host_entry),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .mask       (mask),
        .wr_comp    (wr_comp),
        .rd_comp    (rd_comp)
    );

    pal_ram #(.IDX_W(IDX_W), .COMP_W(COMP_W)) ram_i (
        .clk        (clk),
        .we         (ram_we),
        .waddr      (ram_waddr),
        .wentry     (ram_wentry),
        .pix_addr   (pix_addr),
        .pix_entry  (pix_entry),
        .host_addr  (rd_idx),
        .host_entry (host_entry)
    );

    pal_pixel_path #(.IDX_W(IDX_W), .COMP_W(COMP_W), .OUT_W(OUT_W)) pix_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_idx   (pix_idx),
        .mask      (mask),
        .ram_addr  (pix_addr),
        .ram_entry (pix_entry),
        .pix_r     (pix_r),
        .pix_g     (pix_g),
        .pix_b     (pix_b)
    );
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
    parameter int IDX_W  = 8,
    parameter int HOST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_wr_en,
    input logic              hst_rd_en,
    input logic [1:0]        hst_addr,
    input logic [HOST_W-1:0] hst_wdata,
    input logic [HOST_W-1:0] hst_rdata,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [IDX_W-1:0]  mask,
    input logic [1:0]        wr_comp,
    input logic [1:0]        rd_comp
);
    // R2
    wr_comp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_comp != 2'd3 && rd_comp != 2'd3);

    // R3
    wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_addr == 2'd1 && wr_comp == 2'd2)
        |=> (wr_idx == IDX_W'($past(wr_idx) + 1) && wr_comp == 2'd0));

    // R5
    wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_addr == 2'd0)
        |=> (wr_comp == 2'd0 && wr_idx == $past(hst_wdata[IDX_W-1:0])));

    // R1
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_addr == 2'd3) |=> (mask == $past(hst_wdata[IDX_W-1:0])));

    // R8
    rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd_en && !hst_wr_en && hst_addr == 2'd1 && rd_comp == 2'd2)
        |=> (rd_idx == IDX_W'($past(rd_idx) + 1) && rd_comp == 2'd0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_rd_en |=> $stable(hst_rdata));
endmodule

bind pal_lut pal_lut_chk #(.IDX_W(IDX_W), .HOST_W(HOST_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_wr_en (hst_wr_en),
    .hst_rd_en (hst_rd_en),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .mask      (mask),
    .wr_comp   (wr_comp),
    .rd_comp   (rd_comp)
);

// File: tb/pal_lut_tb.sv
`timescale 1ns/1ps
module pal_lut_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_wr = 1'b0, b_rd = 1'b0;
    logic [1:0] b_addr = 2'd0;
    logic [7:0] b_wdata = 8'd0;
    logic [7:0] b_pix = 8'd0;
    logic [7:0] hst_rdata, pix_r, pix_g, pix_b;

    int checks = 0;
    int failures = 0;
    string phase = "R10";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pal_lut dut_i (
        .clk(clk), .rst_n(rst_n), .hst_wr_en(b_wr), .hst_rd_en(b_rd),
        .hst_addr(b_addr), .hst_wdata(b_wdata), .hst_rdata(hst_rdata),
        .pix_idx(b_pix), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    // behavioural palette model
    int m_r[256], m_g[256], m_b[256];
    bit m_known[256];
    int m_wi, m_ri, m_wc, m_rc, m_mask, m_sr, m_sg;
    int e_r, e_g, e_b, e_rd;
    bit e_pv, e_rdv;

    function automatic int widen(int c);
        return ((c * 4) + (c / 16)) & 255;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wi = 0; m_ri = 0; m_wc = 0; m_rc = 0; m_mask = 255;
            m_sr = 0; m_sg = 0;
            e_r = 0; e_g = 0; e_b = 0; e_rd = 0; e_pv = 1; e_rdv = 1;
        end else begin
            int a;
            a = b_pix & m_mask;
            e_pv = m_known[a];
            e_r = widen(m_r[a]); e_g = widen(m_g[a]); e_b = widen(m_b[a]);
            if (b_rd) begin
                e_rdv = 1;
                case (b_addr)
                    2'd0: e_rd = m_wi;
                    2'd2: e_rd = m_ri;
                    2'd3: e_rd = m_mask;
                    default: begin
                        e_rdv = m_known[m_ri];
                        e_rd = (m_rc == 0) ? m_r[m_ri] : (m_rc == 1) ? m_g[m_ri] : m_b[m_ri];
                        m_rc = m_rc + 1;
                        if (m_rc == 3) begin m_rc = 0; m_ri = (m_ri + 1) % 256; end
                    end
                endcase
            end
            if (b_wr) begin
                case (b_addr)
                    2'd0: begin m_wi = b_wdata; m_wc = 0; end
                    2'd2: begin m_ri = b_wdata; m_rc = 0; end
                    2'd3: m_mask = b_wdata;
                    default: begin
                        if (m_wc == 0) m_sr = b_wdata % 64;
                        else if (m_wc == 1) m_sg = b_wdata % 64;
                        else begin
                            m_r[m_wi] = m_sr; m_g[m_wi] = m_sg; m_b[m_wi] = b_wdata % 64;
                            m_known[m_wi] = 1;
                            m_wi = (m_wi + 1) % 256;
                        end
                        m_wc = (m_wc + 1) % 3;
                    end
                endcase
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (e_rdv) chk({phase, " rdata"}, hst_rdata, e_rd);
            if (e_pv) begin
                chk({phase, " pix_r"}, pix_r, e_r);
                chk({phase, " pix_g"}, pix_g, e_g);
                chk({phase, " pix_b"}, pix_b, e_b);
            end
        end
    end

    task automatic hwr(logic [1:0] a, logic [7:0] d);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic hrd(logic [1:0] a, output int v);
        b_rd = 1'b1; b_addr = a;
        @(negedge clk);
        b_rd = 1'b0;
        v = hst_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5ns * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        for (int i = 0; i < 256; i++) m_known[i] = 0;
        repeat (3) @(negedge clk);
        // R10 reset values
        chk("R10 rdata", hst_rdata, 0);
        chk("R10 pix", pix_r | pix_g | pix_b, 0);
        rst_n = 1'b1;
        @(negedge clk);

        phase = "R1";
        hrd(2'd0, v); chk("R10 wr ptr", v, 0);
        hrd(2'd2, v); chk("R10 rd ptr", v, 0);
        hrd(2'd3, v); chk("R10 mask", v, 255);

        // R2 R3 R4: load the whole palette, full bytes (upper two bits dropped)
        phase = "R3";
        hwr(2'd0, 8'd0);
        for (int i = 0; i < 256; i++) begin
            b_pix = 8'((i * 37) & 255);
            hwr(2'd1, 8'((i * 3 + 200) & 255));
            hwr(2'd1, 8'((i * 5 + 7) & 255));
            hwr(2'd1, 8'(~i));
        end
        phase = "R4";
        hrd(2'd0, v); chk("R4 wr ptr wrapped", v, 0);

        // R6 R7: pixel sweeps under several masks
        phase = "R6";
        for (int i = 0; i < 256; i++) begin b_pix = 8'(i); @(negedge clk); end
        hwr(2'd3, 8'h0F);
        for (int i = 0; i < 64; i++) begin b_pix = 8'((i * 29) & 255); @(negedge clk); end
        hwr(2'd3, 8'h00);
        b_pix = 8'hFF; @(negedge clk);
        phase = "R7";
        chk("R7 masked to entry 0 red", pix_r, widen(m_r[0]));
        hwr(2'd3, 8'hFF);
        b_pix = 8'd3; @(negedge clk);
        chk("R7 widen entry 3 blue", pix_b, widen((~3) & 63));

        // R5: pointer rewrite abandons a partial triple
        phase = "R5";
        hwr(2'd0, 8'd10); hwr(2'd1, 8'd1); hwr(2'd1, 8'd2);
        hwr(2'd0, 8'd20); hwr(2'd1, 8'd11); hwr(2'd1, 8'd12); hwr(2'd1, 8'd13);
        b_pix = 8'd20; @(negedge clk);
        chk("R5 entry 20 red", pix_r, widen(11));
        b_pix = 8'd10; @(negedge clk);
        chk("R5 entry 10 untouched", pix_r, widen((10 * 3 + 200) & 63));

        // R3: no change before blue
        phase = "R3";
        hwr(2'd0, 8'd30); hwr(2'd1, 8'd60); hwr(2'd1, 8'd61);
        b_pix = 8'd30; @(negedge clk);
        chk("R3 partial not committed", pix_r, widen((30 * 3 + 200) & 63));
        hwr(2'd1, 8'd62); @(negedge clk);
        chk("R3 committed after blue", pix_b, widen(62));

        // R8 R4: readback across the wrap
        phase = "R8";
        hwr(2'd2, 8'd254);
        for (int i = 0; i < 9; i++) hrd(2'd1, v);
        hrd(2'd2, v); chk("R8 rd ptr after 3 triples", v, 1);
        hwr(2'd2, 8'd20); hrd(2'd1, v); hrd(2'd1, v);
        chk("R8 green of 20", v, 12);
        hwr(2'd2, 8'd20); hrd(2'd1, v); chk("R8 restart at red", v, 11);

        // R4: wrap during a write at 255
        phase = "R4";
        hwr(2'd0, 8'd255); hwr(2'd1, 8'd5); hwr(2'd1, 8'd6); hwr(2'd1, 8'd7);
        hrd(2'd0, v); chk("R4 wr ptr 255 to 0", v, 0);

        // R9: register reads have no side effect, rdata holds
        phase = "R9";
        hwr(2'd3, 8'h5A);
        hrd(2'd3, v); chk("R9 mask read", v, 90);
        idle(4); chk("R9 rdata held", hst_rdata, 90);
        hrd(2'd0, v); hrd(2'd0, v); chk("R9 repeat read stable", v, 0);

        phase = "R2";
        hwr(2'd0, 8'd40); hwr(2'd1, 8'hFF); hwr(2'd1, 8'hC0); hwr(2'd1, 8'h81);
        hwr(2'd2, 8'd40); hrd(2'd1, v); chk("R2 upper bits dropped", v, 63);
        hrd(2'd1, v); chk("R2 green order", v, 0);
        hrd(2'd1, v); chk("R2 blue order", v, 1);
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule